// File: doc/BRIEF.md
# Dual-compare low-power event timer

This block is a 16-bit up-counter for a low-power subsystem. It either advances once per pulse of a slow free-running tick, or once per edge of one of sixteen external trigger lines. A two-flop synchroniser sits in front of the edge detector. Two compare thresholds watch the counter. A compare match can raise a sticky flag, return the counter to zero, and set or clear a single waveform output. The counter's overflow can also set the waveform output. From these three events, software builds periodic pulses or PWM-style waveforms.

Software reaches the block through a simple synchronous register port. Four word locations are decoded: control at 0x00, count at 0x10, thresholds at 0x20 and status at 0x30. Any other address reads zero and ignores writes. The internal counter is never written directly. A self-clearing load command copies the count register into the counter, and a self-clearing capture command copies the counter into the count register. One interrupt line combines the three sticky flags, each gated by its own enable. A debug-halt input can freeze counting when software asks for that behaviour.

Top module: `lp_event_timer`

## Requirements
- R1: After reset, every register reads 0, `wave_out` is 0 and `irq` is 0.
- R2: The count source is set by control bits 1:0. Code 0 adds one for each cycle in which `tick` is high. While the run bit (control bit 31) is 0, the counter does not change and no compare or overflow event occurs.
- R3: Codes 1, 2 and 3 count rising edges, falling edges and both edges of the trigger input chosen by control bits 7:4. Other trigger lines, and `tick`, have no effect in these modes.
- R4: Writing 1 to control bit 8 loads the count register (0x10, bits 15:0) into the counter on the following clock edge. Writing 1 to control bit 9 copies the counter into the count register on the following clock edge. Each command bit reads as 1 until its copy is done and as 0 afterwards.
- R5: A compare event fires on the increment that makes the counter equal its threshold. Compare 0 uses threshold bits 15:0 and is enabled by control bit 11. Compare 1 uses threshold bits 31:16 and is enabled by control bit 12.
- R6: When control bit 24 is set, a compare 0 event returns the counter to 0 instead of the matched value. Control bit 25 does the same for compare 1.
- R7: An increment from 0xFFFF wraps the counter to 0 and is an overflow event.
- R8: Status bits 0, 1 and 2 latch overflow, compare 0 and compare 1 events. Each bit stays set until 1 is written to that bit of status. Writing 0 leaves it unchanged.
- R9: `irq` is high when at least one status flag is set and its enable is also set. The enables are control bit 16 for overflow, 17 for compare 0 and 20 for compare 1.
- R10: The waveform state is driven by three events. An overflow sets it to 1 if control bit 18 is set. A compare 0 event clears it to 0 if control bit 19 is set. A compare 1 event sets it to 1 if control bit 21 is set. When a clear and a set fall in the same cycle, the clear wins.
- R11: `wave_out` equals the waveform state XOR control bit 22 while control bit 13 is 1, and is 0 while control bit 13 is 0.
- R12: With control bit 30 set, the counter holds while `dbg_halt` is high. With bit 30 clear, `dbg_halt` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Free-running count enable, one pulse per count |
| trig_in | input | 16 | Asynchronous external trigger lines |
| dbg_halt | input | 1 | High while the system is halted for debug |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr`, combinational |
| wave_out | output | 1 | Waveform output |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench tries the count source with six vectors:
- **Tick mode.** Tick pulses are counted while the trigger lines toggle. This shows that the triggers are ignored in tick mode.
- **Edge modes.** Toggle trains of odd and even length are applied to the selected trigger line. Rising, falling and both-edge counting give different totals for the same train, which separates the three edge modes.
- **Neighbour noise.** A neighbouring trigger line toggles alongside the selected one, and `tick` is held high. This shows that the selected line alone feeds the counter.

Directed tests then cover the following:
- A threshold reached with its compare enabled, and another threshold reached with its compare disabled.
- A compare match that resets the counter.
- Wrap from 0xFFFF.
- Write-one-to-clear applied to a single flag.
- A compare 0 clear and a compare 1 set landing in the same cycle.
- Inversion and output gating.
- Debug halt with the freeze bit set and with it clear.

// File: rtl/lpt_pkg.sv
// Package: shared register addresses, control bit positions and count-mode
// codes for the dual-compare event timer. Assumes a 32-bit register word.
package lpt_pkg;
    localparam int B_MODE  = 0;
    localparam int B_TSEL  = 4;
    localparam int B_LOAD  = 8;
    localparam int B_CAPT  = 9;
    localparam int B_C0EN  = 11;
    localparam int B_C1EN  = 12;
    localparam int B_OUTEN = 13;
    localparam int B_OVFIE = 16;
    localparam int B_C0IE  = 17;
    localparam int B_OVFOE = 18;
    localparam int B_C0OE  = 19;
    localparam int B_C1IE  = 20;
    localparam int B_C1OE  = 21;
    localparam int B_INV   = 22;
    localparam int B_C0RST = 24;
    localparam int B_C1RST = 25;
    localparam int B_DBG   = 30;
    localparam int B_RUN   = 31;

    localparam int THR1_LSB = 16;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_CNT  = 8'h10;
    localparam logic [7:0] A_THR  = 8'h20;
    localparam logic [7:0] A_STAT = 8'h30;

    // Control bits that are stored as plain read/write state.
    localparam logic [31:0] CTRL_RW_MASK =
        (32'h3 << B_MODE) | (32'hF << B_TSEL) |
        (32'h1 << B_C0EN) | (32'h1 << B_C1EN) | (32'h1 << B_OUTEN) |
        (32'h1 << B_OVFIE) | (32'h1 << B_C0IE) | (32'h1 << B_OVFOE) |
        (32'h1 << B_C0OE) | (32'h1 << B_C1IE) | (32'h1 << B_C1OE) |
        (32'h1 << B_INV) | (32'h1 << B_C0RST) | (32'h1 << B_C1RST) |
        (32'h1 << B_DBG) | (32'h1 << B_RUN);

    typedef enum logic [1:0] {
        CM_TICK = 2'd0,
        CM_RISE = 2'd1,
        CM_FALL = 2'd2,
        CM_BOTH = 2'd3
    } cnt_mode_e;
endpackage

// File: rtl/lpt_trig_edge.sv
// Trigger synchroniser and edge detector. Every trigger line passes through
// SYNC_STAGES flops, plus one history flop. The chosen line's edge is decoded
// by mode. Assumes the select field is stable while edges are counted.
module lpt_trig_edge
    import lpt_pkg::*;
#(
    parameter int N_TRIG      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = $clog2(N_TRIG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  sel,
    input  cnt_mode_e         mode,
    output logic              edge_hit
);
    logic [N_TRIG-1:0] sq [0:SYNC_STAGES];
    logic cur, prv;

    // Shift all trigger lines through the synchroniser and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i <= SYNC_STAGES; i++) sq[i] <= '0;
        end else begin
            sq[0] <= trig_in;
            for (int i = 1; i <= SYNC_STAGES; i++) sq[i] <= sq[i-1];
        end
    end

    assign cur = sq[SYNC_STAGES-1][sel];
    assign prv = sq[SYNC_STAGES][sel];

    // Decode the selected line's transition according to the count mode.
    always_comb begin
        case (mode)
            CM_RISE: edge_hit = cur & ~prv;
            CM_FALL: edge_hit = ~cur & prv;
            CM_BOTH: edge_hit = cur ^ prv;
            default: edge_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpt_counter.sv
// Counter with N_CMP compare channels. A pending load overrides counting in
// the same cycle. Compare hits fire on the increment that reaches a threshold.
// A hit on a channel whose reset is enabled sends the counter to zero.
module lpt_counter #(
    parameter int CNT_W = 16,
    parameter int N_CMP = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inc,
    input  logic                        load,
    input  logic [CNT_W-1:0]            load_val,
    input  logic [N_CMP-1:0][CNT_W-1:0] cmp_val,
    input  logic [N_CMP-1:0]            cmp_en,
    input  logic [N_CMP-1:0]            rst_en,
    output logic [CNT_W-1:0]            cnt_q,
    output logic                        ovf,
    output logic [N_CMP-1:0]            hit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_inc;
    logic [N_CMP-1:0] hit_rst;
    logic             step;

    assign step    = inc & ~load;
    assign cnt_inc = cnt_q + 1'b1;
    assign ovf     = step && (cnt_q == CNT_MAX);

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        assign hit[g]     = step && cmp_en[g] && (cnt_inc == cmp_val[g]);
        assign hit_rst[g] = hit[g] & rst_en[g];
    end

    // Update the counter: load, then step (with compare reset), else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (load)    cnt_q <= load_val;
        else if (step)    cnt_q <= (|hit_rst) ? '0 : cnt_inc;
    end
endmodule

// File: rtl/lpt_wave.sv
// Waveform state driven by overflow (set), compare 0 (clear) and compare 1
// (set), each under its own enable. The clear wins over the sets. The pin
// value is the state with optional inversion, gated by the output enable.
module lpt_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic hit0,
    input  logic hit1,
    input  logic ovf_oe,
    input  logic c0_oe,
    input  logic c1_oe,
    input  logic inv,
    input  logic out_en,
    output logic wave_q,
    output logic wave_out
);
    // Hold the waveform state, applying clear before set.
    always_ff @(posedge clk) begin
        if (!rst_n)                                wave_q <= 1'b0;
        else if (hit0 && c0_oe)                    wave_q <= 1'b0;
        else if ((ovf && ovf_oe) || (hit1 && c1_oe)) wave_q <= 1'b1;
    end

    assign wave_out = out_en & (wave_q ^ inv);
endmodule

// File: rtl/lp_event_timer.sv
// Top of the dual-compare event timer. Holds the register file, command
// pendings, sticky flags and interrupt, and ties together the trigger, counter
// and waveform units. Assumes one register access per cycle, with the
// combinational read selected by addr.
module lp_event_timer
    import lpt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_TRIG = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic              dbg_halt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wave_out,
    output logic              irq
);
    localparam int SEL_W  = $clog2(N_TRIG);
    localparam int N_FLAG = 3;

    logic [DATA_W-1:0]     ctrl_q;
    logic                  ld_pend, cap_pend;
    logic [CNT_W-1:0]      cnt_reg, cnt_q;
    logic [1:0][CNT_W-1:0] thr_q;
    logic [N_FLAG-1:0]     flags, flag_set, flag_clr, flag_ie;
    logic [1:0]            hit;
    logic                  ovf, edge_hit, src, inc, frozen, wave_q;
    logic                  wr_ctrl, wr_cnt, wr_thr, wr_stat;
    cnt_mode_e             mode;

    assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_cnt  = wr_en && (addr == ADDR_W'(A_CNT));
    assign wr_thr  = wr_en && (addr == ADDR_W'(A_THR));
    assign wr_stat = wr_en && (addr == ADDR_W'(A_STAT));

    assign mode   = cnt_mode_e'(ctrl_q[B_MODE +: 2]);
    assign frozen = dbg_halt & ctrl_q[B_DBG];
    assign src    = (mode == CM_TICK) ? tick : edge_hit;
    assign inc    = ctrl_q[B_RUN] & ~frozen & src;

    // Control register and self-clearing load/capture commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            ld_pend  <= 1'b0;
            cap_pend <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_q   <= wdata & CTRL_RW_MASK;
            ld_pend  <= wdata[B_LOAD];
            cap_pend <= wdata[B_CAPT];
        end else begin
            ld_pend  <= 1'b0;
            cap_pend <= 1'b0;
        end
    end

    // Count register: a software write, else a capture of the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_reg <= '0;
        else if (wr_cnt)   cnt_reg <= wdata[CNT_W-1:0];
        else if (cap_pend) cnt_reg <= cnt_q;
    end

    // Threshold register holding both compare values.
    always_ff @(posedge clk) begin
        if (!rst_n) thr_q <= '0;
        else if (wr_thr) begin
            thr_q[0] <= wdata[0 +: CNT_W];
            thr_q[1] <= wdata[THR1_LSB +: CNT_W];
        end
    end

    assign flag_set = {hit[1], hit[0], ovf};
    assign flag_clr = wr_stat ? wdata[N_FLAG-1:0] : '0;
    assign flag_ie  = {ctrl_q[B_C1IE], ctrl_q[B_C0IE], ctrl_q[B_OVFIE]};

    // Sticky flags: a new event wins over a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~flag_clr) | flag_set;
    end

    assign irq = |(flags & flag_ie);

    // Read multiplexer for the four decoded locations.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_CTRL): rdata = ctrl_q | (DATA_W'(ld_pend) << B_LOAD)
                                            | (DATA_W'(cap_pend) << B_CAPT);
            ADDR_W'(A_CNT):  rdata = DATA_W'(cnt_reg);
            ADDR_W'(A_THR):  rdata = DATA_W'(thr_q[0]) | (DATA_W'(thr_q[1]) << THR1_LSB);
            ADDR_W'(A_STAT): rdata = DATA_W'(flags);
            default:         rdata = '0;
        endcase
    end

    lpt_trig_edge #(.N_TRIG(N_TRIG), .SYNC_STAGES(2)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .sel(ctrl_q[B_TSEL +: SEL_W]), .mode(mode), .edge_hit(edge_hit)
    );

    lpt_counter #(.CNT_W(CNT_W), .N_CMP(2)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc), .load(ld_pend),
        .load_val(cnt_reg), .cmp_val(thr_q),
        .cmp_en({ctrl_q[B_C1EN], ctrl_q[B_C0EN]}),
        .rst_en({ctrl_q[B_C1RST], ctrl_q[B_C0RST]}),
        .cnt_q(cnt_q), .ovf(ovf), .hit(hit)
    );

    lpt_wave u_wave (
        .clk(clk), .rst_n(rst_n), .ovf(ovf), .hit0(hit[0]), .hit1(hit[1]),
        .ovf_oe(ctrl_q[B_OVFOE]), .c0_oe(ctrl_q[B_C0OE]), .c1_oe(ctrl_q[B_C1OE]),
        .inv(ctrl_q[B_INV]), .out_en(ctrl_q[B_OUTEN]),
        .wave_q(wave_q), .wave_out(wave_out)
    );
endmodule

// File: rtl/lpt_checker.sv
// Checker for lp_event_timer: temporal properties on counter hold, command
// self-clear, flag stickiness, overflow wrap, waveform clear and interrupt.
// It is bound to every instance of the top module.
module lpt_checker
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      ctrl_q,
    input logic             ld_pend,
    input logic [CNT_W-1:0] cnt_q,
    input logic [2:0]       flags,
    input logic             ovf,
    input logic             hit0,
    input logic             wave_q,
    input logic             irq,
    input logic             dbg_halt,
    input logic             wr_en,
    input logic [7:0]       addr,
    input logic [31:0]      wdata
);
    logic wr_ctrl, wr_stat;
    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_stat = wr_en && (addr == A_STAT);

    // R2: a stopped counter holds unless a load is pending.
    p_stop_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[B_RUN] && !ld_pend) |=> $stable(cnt_q));

    // R12: a debug halt with the freeze bit set holds the counter.
    p_halt_freezes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt && ctrl_q[B_DBG] && !ld_pend) |=> $stable(cnt_q));

    // R4: a pending load is gone one cycle later unless rewritten.
    p_load_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pend && !wr_ctrl) |=> !ld_pend);

    // R7: an overflow event leaves the counter at zero.
    p_ovf_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == '0));

    // R10: an enabled compare 0 event clears the waveform state.
    p_c0_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hit0 && ctrl_q[B_C0OE]) |=> !wave_q);

    // R9: the interrupt needs at least one set flag.
    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 3'b000));

    // R8: each flag stays set until a one is written to it.
    for (genvar i = 0; i < 3; i++) begin : g_sticky
        p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(wr_stat && wdata[i])) |=> flags[i]);
    end
endmodule

bind lp_event_timer lpt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .ld_pend(ld_pend),
    .cnt_q(cnt_q), .flags(flags), .ovf(ovf), .hit0(hit[0]),
    .wave_q(wave_q), .irq(irq), .dbg_halt(dbg_halt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata)
);

// File: tb/sim_lp_event_timer.sv
// Bench for lp_event_timer: a vector table for the count sources, then
// directed tests for reset, compare, overflow, flags, waveform and debug halt.
module sim_lp_event_timer;
    localparam int CLK_NS = 4;
    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h10, A_THR = 8'h20, A_STAT = 8'h30;
    localparam logic [31:0] LOAD = 32'h1 << 8,  CAPT = 32'h1 << 9,
                            C0EN = 32'h1 << 11, C1EN = 32'h1 << 12,
                            OUTEN = 32'h1 << 13, OVFIE = 32'h1 << 16,
                            C0IE = 32'h1 << 17, OVFOE = 32'h1 << 18,
                            C0OE = 32'h1 << 19, C1OE = 32'h1 << 21,
                            INV = 32'h1 << 22, C0RST = 32'h1 << 24,
                            DBG = 32'h1 << 30, RUN = 32'h1 << 31;
    localparam int NV = 6;
    localparam int V_MODE [NV] = '{0, 1, 2, 3, 1, 3};
    localparam int V_SEL  [NV] = '{0, 3, 3, 7, 15, 0};
    localparam int V_N    [NV] = '{5, 5, 5, 6, 7, 4};

    logic        clk = 0, rst_n = 0, tick = 0, dbg_halt = 0, wr_en = 0;
    logic [15:0] trig_in = '0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata, got;
    logic        wave_out, irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #(CLK_NS/2) clk = ~clk;

    lp_event_timer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig_in),
        .dbg_halt(dbg_halt), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wave_out(wave_out), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic pulse(input int n);
        repeat (n) begin tick = 1; @(negedge clk); tick = 0; end
    endtask

    task automatic load(input logic [15:0] v, input logic [31:0] base);
        wr(A_CNT, 32'(v)); wr(A_CTRL, base | LOAD); idle(1);
    endtask

    task automatic capture(input logic [31:0] base, output logic [31:0] v);
        wr(A_CTRL, base | CAPT); idle(1); rd(A_CNT, v);
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3); rst_n = 1; idle(1);
        // R1: reset state.
        rd(A_CTRL, got); chk("R1 ctrl", got, 0);
        rd(A_CNT, got);  chk("R1 count", got, 0);
        rd(A_THR, got);  chk("R1 thr", got, 0);
        rd(A_STAT, got); chk("R1 status", got, 0);
        chk("R1 wave", 32'(wave_out), 0);
        chk("R1 irq", 32'(irq), 0);

        // R2/R3: count-source vectors.
        for (int v = 0; v < NV; v++) begin
            logic [31:0] base, exp;
            base = (32'(V_MODE[v])) | (32'(V_SEL[v]) << 4);
            load(16'h0, base);
            wr(A_CTRL, base | RUN);
            if (V_MODE[v] == 0) begin
                for (int k = 0; k < V_N[v]; k++) begin
                    trig_in = ~trig_in; pulse(1); idle(1);
                end
            end else begin
                tick = 1;
                for (int k = 0; k < V_N[v]; k++) begin
                    trig_in[V_SEL[v]] = ~trig_in[V_SEL[v]];
                    trig_in[(V_SEL[v] + 1) % 16] = ~trig_in[(V_SEL[v] + 1) % 16];
                    idle(3);
                end
                tick = 0;
            end
            idle(4);
            capture(base, got);
            case (V_MODE[v])
                0: exp = 32'(V_N[v]);
                1: exp = 32'((V_N[v] + 1) / 2);
                2: exp = 32'(V_N[v] / 2);
                default: exp = 32'(V_N[v]);
            endcase
            chk(V_MODE[v] == 0 ? "R2 tick count" : "R3 edge count", got, exp);
            trig_in = '0; idle(4);
        end

        // R4: load command reads 1 while pending, then clears itself.
        wr(A_CNT, 32'h0042); wr(A_CTRL, LOAD);
        rd(A_CTRL, got); chk("R4 load pending", got & LOAD, LOAD);
        idle(1);
        rd(A_CTRL, got); chk("R4 load selfclear", got & LOAD, 0);
        capture(0, got); chk("R4 capture", got, 32'h42);

        // R2: ticks with run clear are ignored.
        pulse(3); capture(0, got); chk("R2 stopped", got, 32'h42);

        // R5: compare 0 enabled at 5, compare 1 disabled at 3.
        wr(A_STAT, 7); load(16'h0, 0);
        wr(A_THR, (32'd3 << 16) | 32'd5);
        wr(A_CTRL, RUN | C0EN | C0IE);
        pulse(4);
        rd(A_STAT, got); chk("R5 no early event", got, 0);
        pulse(1);
        rd(A_STAT, got); chk("R5 compare0 flag", got, 32'h2);
        chk("R9 irq on compare0", 32'(irq), 1);
        wr(A_STAT, 2);
        rd(A_STAT, got); chk("R8 w1c clears", got, 0);
        chk("R9 irq cleared", 32'(irq), 0);

        // R6: compare 0 reset at 4.
        wr(A_THR, 32'd4); load(16'h0, 0);
        wr(A_CTRL, RUN | C0EN | C0RST);
        pulse(4); capture(RUN | C0EN | C0RST, got); chk("R6 reset to zero", got, 0);
        pulse(1); capture(RUN | C0EN | C0RST, got); chk("R6 counts on", got, 1);

        // R7/R8/R9: overflow and sticky flags.
        wr(A_CTRL, 0); wr(A_STAT, 7); load(16'hFFFE, 0);
        wr(A_CTRL, RUN | OVFIE);
        pulse(1);
        rd(A_STAT, got); chk("R7 no flag before wrap", got, 0);
        pulse(1);
        capture(RUN | OVFIE, got); chk("R7 wrap to zero", got, 0);
        rd(A_STAT, got); chk("R7 overflow flag", got, 1);
        chk("R9 irq on overflow", 32'(irq), 1);
        pulse(2);
        wr(A_STAT, 2);
        rd(A_STAT, got); chk("R8 other flag kept", got, 1);
        wr(A_CTRL, RUN);
        chk("R9 irq masked", 32'(irq), 0);

        // R10/R11: waveform.
        wr(A_CTRL, 0); load(16'h0, 0);
        wr(A_THR, (32'd2 << 16) | 32'd8);
        wr(A_CTRL, RUN | C0EN | C1EN | OUTEN | C0OE | C1OE | OVFOE);
        chk("R11 wave starts low", 32'(wave_out), 0);
        pulse(2);
        chk("R10 compare1 sets", 32'(wave_out), 1);
        wr(A_THR, (32'd5 << 16) | 32'd5);
        pulse(3);
        chk("R10 clear wins", 32'(wave_out), 0);
        wr(A_CTRL, RUN | C0EN | C1EN | OUTEN | INV);
        chk("R11 inverted", 32'(wave_out), 1);
        wr(A_CTRL, RUN | C0EN | C1EN | INV);
        chk("R11 gated off", 32'(wave_out), 0);

        // R12: debug halt.
        wr(A_CTRL, 0); load(16'd10, 0);
        dbg_halt = 1;
        wr(A_CTRL, RUN | DBG);
        pulse(3); capture(RUN | DBG, got); chk("R12 frozen", got, 10);
        wr(A_CTRL, RUN);
        pulse(3); capture(RUN, got); chk("R12 runs when bit clear", got, 13);
        dbg_halt = 0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule